// File: doc/BRIEF.md
# Write-in-progress status reporter

This block sits on the read path of a byte-wide non-volatile memory. While the memory's internal write cycle runs, it replaces the read data with a status byte so that a host can learn when the write has finished by reading, with no need for a dedicated busy pin. When no write is running, reads get the array data unchanged.

During a write, bit 7 of each returned byte is the complement of bit 7 of the last byte handed to the write sequencer. Bit 6 flips on every read while the write runs and starts at 1. All other bits read as zero. The host keeps its polling address fixed. It stops when bit 6 no longer changes between two reads, or when bit 7 matches the value it wrote. Reads are one cycle long: a one-cycle strobe gives one registered result one cycle later.

Top module: `wip_status_rdout`

## Requirements
- R1: While rst_ni is low, rd_valid_o is 0 and rd_data_o is 0.
- R2: When rd_strobe_i is high and busy_i is low, in the next cycle rd_valid_o is 1 and rd_data_o equals array_data_i as sampled in the strobe cycle.
- R3: When rd_strobe_i is high and busy_i is high, bit 7 of rd_data_o in the next cycle is the inverse of bit 7 of the last byte captured through load_valid_i before the strobe cycle.
- R4: The first read after busy_i rises returns bit 6 equal to 1.
- R5: Each read while busy_i is high inverts bit 6 relative to the previous busy read. Clock cycles with no read strobe leave the toggle state unchanged.
- R6: In a busy read, bits 5 down to 0 of rd_data_o are 0.
- R7: rd_valid_o is high exactly in the cycle after each strobe cycle and low otherwise. rd_data_o holds its value in cycles that follow no strobe.
- R8: After busy_i falls, reads return array data again, so bit 7 matches the written value. A later busy period restarts bit 6 at 1.
- R9: A byte captured by load_valid_i replaces the stored last byte, whether or not a write is busy. A capture alone produces no read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| load_valid_i | input | 1 | Byte loaded into write sequencer this cycle |
| load_data_i | input | 8 | Loaded byte |
| rd_strobe_i | input | 1 | One-cycle read request |
| array_data_i | input | 8 | Array data for the current read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Read result: array data or status byte |

## Verification
A stuck or mis-initialised toggle register shows up on bit 6 at the first busy read, and a register that advances on idle clocks shows up at the second busy read if idle cycles are placed between the reads. A stale last-byte register inverts bit 7 on the very next busy read after a new load. A wrong source select is seen one cycle after the strobe, as array data in place of status or the reverse. The scoreboard compares every returned byte, so each of these faults is caught in the cycle it occurs.

// File: rtl/wip_pkg.sv
package wip_pkg;
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/wip_last_byte.sv
module wip_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] last_o
);
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           last_q <= '0;
    else if (load_valid_i) last_q <= load_data_i;
  end

  assign last_o = last_q;

  p_load_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i |=> last_q == $past(load_data_i));
  p_load_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_i |=> $stable(last_q));
endmodule

// File: rtl/wip_toggle_gen.sv
module wip_toggle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_strobe_i,
  output logic tog_o
);
  logic tog_q;

  // Re-arms to 1 whenever idle; advances only on busy reads.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tog_q <= 1'b1;
    else if (!busy_i)     tog_q <= 1'b1;
    else if (rd_strobe_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  p_tog_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> tog_q);
  p_tog_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rd_strobe_i |=> tog_q != $past(tog_q));
  p_tog_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rd_strobe_i |=> $stable(tog_q));
endmodule

// File: rtl/wip_rd_mux.sv
module wip_rd_mux
  import wip_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_strobe_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  rd_src_e           src;

  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == POLL_BIT)     begin : g_poll
      assign status_d[b] = ~last_i[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_d[b] = tog_i;
    end else begin : g_zero
      assign status_d[b] = 1'b0;
    end
  end

  assign src = busy_i ? SRC_STATUS : SRC_ARRAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_strobe_i;
      if (rd_strobe_i) data_q <= (src == SRC_STATUS) ? status_d : array_data_i;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  p_valid_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> rd_valid_o);
  p_valid_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> !rd_valid_o && $stable(rd_data_o));
  p_idle_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i && !busy_i |=> rd_data_o == $past(array_data_i));
  p_poll_inv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i && busy_i |=> rd_data_o[POLL_BIT] != $past(last_i[POLL_BIT]));
  p_zero_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i && busy_i |=> (rd_data_o & ~FLAG_MASK) == '0);
endmodule

// File: rtl/wip_status_rdout.sv
module wip_status_rdout #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] last_byte;
  logic              tog;

  wip_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_valid_i(load_valid_i),
    .load_data_i (load_data_i),
    .last_o      (last_byte)
  );

  wip_toggle_gen u_tog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .rd_strobe_i(rd_strobe_i),
    .tog_o      (tog)
  );

  wip_rd_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .TOG_BIT (TOG_BIT)
  ) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_strobe_i (rd_strobe_i),
    .busy_i      (busy_i),
    .last_i      (last_byte),
    .tog_i       (tog),
    .array_data_i(array_data_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !rd_valid_o && rd_data_o == '0);
endmodule

// File: tb/wip_status_rdout_tb_top.sv
module wip_status_rdout_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0;
  logic       load_valid_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] array_data_i = '0;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] last_m = '0;
  logic       tog_m = 1'b1;

  always #2.5 clk_i = ~clk_i;

  wip_status_rdout dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_busy(input logic v);
    busy_i = v;
    if (!v) tog_m = 1'b1;
    tick();
  endtask

  task automatic load(input logic [7:0] b);
    load_valid_i = 1'b1; load_data_i = b; last_m = b;
    tick();
    load_valid_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] arr, input string tag);
    rd_strobe_i = 1'b1; array_data_i = arr;
    if (busy_i) begin
      exp_q.push_back({~last_m[7], tog_m, 6'b0});
      tog_m = ~tog_m;
    end else begin
      exp_q.push_back(arr);
    end
    tag_q.push_back(tag);
    tick();
    rd_strobe_i = 1'b0; array_data_i = 8'hEE;
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 unexpected result act=%02h exp=none", rd_data_o);
      end else begin
        check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", {7'b0, rd_valid_o}, 8'h00);
    check("R1 reset data", rd_data_o, 8'h00);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    idle(2);

    rd(8'h5A, "R2 idle pass a");
    rd(8'hC3, "R2 idle pass b");
    load(8'h80);                       // R9: load alone gives no result
    idle(2);
    set_busy(1'b1);
    rd(8'h11, "R3 R4 first busy read");
    idle(3);                           // R5: idle clocks do not advance
    rd(8'h22, "R5 second busy read");
    rd(8'h33, "R5 R6 third busy read");
    load(8'h01);                       // R9: load during busy
    rd(8'h44, "R9 R3 read after new load");
    idle(1);
    held = rd_data_o;
    idle(3);
    check("R7 data hold", rd_data_o, held);
    check("R7 valid low", {7'b0, rd_valid_o}, 8'h00);
    set_busy(1'b0);
    rd(8'h01, "R8 done bit7 matches");
    rd(8'hA5, "R8 array again");
    load(8'h7F);
    set_busy(1'b1);
    rd(8'h00, "R8 R4 restart toggle");
    rd(8'h00, "R5 flip after restart");
    set_busy(1'b0);
    idle(3);
    check("R7 no missing results", 8'(exp_q.size()), 8'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule